// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the command decoder of a byte-wide parallel NOR flash. It takes one qualified write event per cycle, each with an address and a data byte. It follows the multi-write unlock and command sequences and decides what a read returns in the same cycle. A read can return array data, fixed identifier codes, per-sector protection status, or operation status. It holds one protection bit per sector. It starts program and erase operations and times them with a fixed busy count. It can also suspend a running erase and resume it.

The array is not part of this block. The array's read data arrives on `array_rdata_i` and is passed through when the block is in array-read mode. A finished program or erase is reported to the array by a one-cycle strobe. The strobe comes with the latched address and data, or with the mask of sectors to erase. A sector is the top `SECT_W` bits of the byte address. Unlock address matches use only address bits [10:0].

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode. `rd_data_o` equals `array_rdata_i`, `busy_o` is 0 and all protection bits are clear.
- R2: The write sequence AAh@555h, 55h@2AAh, 90h@555h enters autoselect mode. A read with address bits [1:0] = 00 returns 37h. A read with 01 returns 86h. A read with 11 returns 7Fh.
- R3: In autoselect mode a read with address bits [1:0] = 10 returns 01h if the sector given by the read address's top bits is protected. It returns 00h if that sector is unprotected.
- R4: At any step of a sequence, a write whose address or data is not the expected next value returns the block to array-read mode. Program and erase start only after a complete unlock.
- R5: The sequence unlock + A0h@555h, followed by one write, latches that write's address and data. `busy_o` then stays high for `BUSY_CYCLES` cycles. In the last of these cycles `pgm_we_o` pulses with the latched values. The block then returns to array-read mode.
- R6: A program or erase aimed at a protected sector has no effect. No busy period follows, no strobe is issued, and the block is back in array-read mode.
- R7: While `busy_o` is high, a read returns status. Bit 7 is 0, bit 6 is a toggle bit that inverts after every read, and all other bits are 0.
- R8: The sequence unlock + 80h@555h, AAh@555h, 55h@2AAh ends with one more write. 30h at a sector address erases that sector. 10h@555h erases every unprotected sector. `ers_we_o` pulses with the sector mask when the busy count ends.
- R9: While an erase is busy, a write of B0h suspends it and `busy_o` drops. The count is frozen. A read from a suspended sector returns status with bit 7 = 1 and bit 6 = the frozen toggle bit. A read from any other sector returns array data.
- R10: While suspended, a write of 30h resumes the erase. The cycle that carries the B0h write does not advance the count, so an erase suspended once is busy for `BUSY_CYCLES`+1 sampled cycles in total.
- R11: Any write while in autoselect mode (F0h included) returns the block to array-read mode.
- R12: `prot_wr_i` sets the protection bit of sector `prot_sector_i` to `prot_val_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Qualified write event |
| wr_addr_i | input | ADDR_W | Latched write address |
| wr_data_i | input | 8 | Latched write data |
| rd_i | input | 1 | Read request (advances the toggle bit while busy) |
| rd_addr_i | input | ADDR_W | Read address |
| array_rdata_i | input | 8 | Data from the array at `rd_addr_i` |
| rd_data_o | output | 8 | Read data |
| prot_wr_i | input | 1 | Protection bit update |
| prot_sector_i | input | SECT_W | Sector to update |
| prot_val_i | input | 1 | New protection value |
| pgm_we_o | output | 1 | Program commit strobe |
| pgm_addr_o | output | ADDR_W | Program address |
| pgm_data_o | output | 8 | Program data |
| ers_we_o | output | 1 | Erase commit strobe |
| ers_mask_o | output | 2**SECT_W | Sectors to erase |
| busy_o | output | 1 | Program or erase running |

## Verification
The sequence state is visible on `rd_data_o` in the same cycle as a read. A machine left in a stale unlock or autoselect state shows up at the first array read as an identifier code instead of array data. A wrong busy count moves the commit strobe by at least one cycle and changes the number of busy cycles. A toggle bit that skips or double-steps shows up at the second status read. A wrong suspend mask shows up as status returned for the wrong sector. The bench compares every port against a behavioural model on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_AUTO, ST_PGM_ARM,
    ST_ERS_UNL0, ST_ERS_UNL1, ST_ERS_UNL2,
    ST_BUSY_PGM, ST_BUSY_ERS, ST_SUSP
  } fsm_state_e;

  localparam logic [7:0] CMD_UNL_A  = 8'hAA;
  localparam logic [7:0] CMD_UNL_B  = 8'h55;
  localparam logic [7:0] CMD_AUTO   = 8'h90;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_ERS    = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;

  localparam logic [10:0] ADR_UNL_A = 11'h555;
  localparam logic [10:0] ADR_UNL_B = 11'h2AA;

  localparam logic [7:0] ID_MFR  = 8'h37;
  localparam logic [7:0] ID_DEV  = 8'h86;
  localparam logic [7:0] ID_CONT = 8'h7F;
endpackage

// File: rtl/flash_prot_bank.sv
module flash_prot_bank #(
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_wr_i,
  input  logic [SECT_W-1:0] prot_sector_i,
  input  logic              prot_val_i,
  output logic [NSECT-1:0]  prot_o
);
  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else if (prot_wr_i && prot_sector_i == SECT_W'(g)) bit_q <= prot_val_i;
    end
    assign prot_o[g] = bit_q;
  end

  AST_PROT_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_wr_i |=> prot_o[$past(prot_sector_i)] == $past(prot_val_i)); // R12
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECT_W      = 3,
  parameter int BUSY_CYCLES = 24,
  localparam int NSECT = 1 << SECT_W,
  localparam int CNT_W = $clog2(BUSY_CYCLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_i,
  input  logic [NSECT-1:0]  prot_i,
  output fsm_state_e        state_o,
  output logic              tog_o,
  output logic [NSECT-1:0]  mask_o,
  output logic              pgm_we_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [7:0]        pgm_data_o,
  output logic              ers_we_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

  fsm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NSECT-1:0]  mask_q, mask_d, ers_sel;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [7:0]        pd_q, pd_d;
  logic              tog_q;

  logic [SECT_W-1:0] wr_sect;
  logic [NSECT-1:0]  wr_sect_oh;
  logic              at_a, at_b, cnt_end;

  assign wr_sect    = wr_addr_i[ADDR_W-1 -: SECT_W];
  assign wr_sect_oh = NSECT'(1) << wr_sect;
  assign at_a       = wr_addr_i[10:0] == ADR_UNL_A;
  assign at_b       = wr_addr_i[10:0] == ADR_UNL_B;
  assign cnt_end    = cnt_q == CNT_LAST;

  always_comb begin
    ers_sel = '0;
    if (wr_data_i == CMD_SECT)             ers_sel = wr_sect_oh & ~prot_i;
    else if (wr_data_i == CMD_CHIP && at_a) ers_sel = ~prot_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    unique case (state_q)
      ST_READ:
        if (wr_i && at_a && wr_data_i == CMD_UNL_A) state_d = ST_UNL1;
      ST_UNL1:
        if (wr_i) state_d = (at_b && wr_data_i == CMD_UNL_B) ? ST_UNL2 : ST_READ;
      ST_UNL2:
        if (wr_i) begin
          state_d = ST_READ;
          if (at_a) begin
            case (wr_data_i)
              CMD_AUTO: state_d = ST_AUTO;
              CMD_PGM:  state_d = ST_PGM_ARM;
              CMD_ERS:  state_d = ST_ERS_UNL0;
              default:  state_d = ST_READ;
            endcase
          end
        end
      ST_AUTO:
        if (wr_i) state_d = ST_READ;
      ST_PGM_ARM:
        if (wr_i) begin
          if (prot_i[wr_sect]) state_d = ST_READ;
          else begin
            state_d = ST_BUSY_PGM;
            cnt_d   = '0;
            pa_d    = wr_addr_i;
            pd_d    = wr_data_i;
          end
        end
      ST_ERS_UNL0:
        if (wr_i) state_d = (at_a && wr_data_i == CMD_UNL_A) ? ST_ERS_UNL1 : ST_READ;
      ST_ERS_UNL1:
        if (wr_i) state_d = (at_b && wr_data_i == CMD_UNL_B) ? ST_ERS_UNL2 : ST_READ;
      ST_ERS_UNL2:
        if (wr_i) begin
          if (|ers_sel) begin
            state_d = ST_BUSY_ERS;
            cnt_d   = '0;
            mask_d  = ers_sel;
          end else state_d = ST_READ;
        end
      ST_BUSY_PGM:
        if (cnt_end) state_d = ST_READ;
        else         cnt_d   = cnt_q + 1'b1;
      ST_BUSY_ERS:
        if (cnt_end)                             state_d = ST_READ;
        else if (wr_i && wr_data_i == CMD_SUSP)  state_d = ST_SUSP;
        else                                     cnt_d   = cnt_q + 1'b1;
      ST_SUSP:
        if (wr_i && wr_data_i == CMD_RESUME) state_d = ST_BUSY_ERS;
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      cnt_q   <= '0;
      mask_q  <= '0;
      pa_q    <= '0;
      pd_q    <= '0;
      tog_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mask_q  <= mask_d;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
      if (rd_i && busy_o) tog_q <= ~tog_q;
    end
  end

  assign busy_o     = state_q == ST_BUSY_PGM || state_q == ST_BUSY_ERS;
  assign pgm_we_o   = state_q == ST_BUSY_PGM && cnt_end;
  assign ers_we_o   = state_q == ST_BUSY_ERS && cnt_end;
  assign state_o    = state_q;
  assign tog_o      = tog_q;
  assign mask_o     = mask_q;
  assign pgm_addr_o = pa_q;
  assign pgm_data_o = pd_q;

  AST_DONE_TO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_we_o || ers_we_o) |=> state_q == ST_READ); // R5
  AST_TOGGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_i) |=> tog_q != $past(tog_q)); // R7
  AST_SUSP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP) |=> $stable(cnt_q)); // R9
  AST_AUTO_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AUTO && wr_i) |=> state_q == ST_READ); // R11
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  fsm_state_e        state_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_rdata_i,
  input  logic              tog_i,
  input  logic [NSECT-1:0]  mask_i,
  input  logic [NSECT-1:0]  prot_i,
  output logic [7:0]        rd_data_o
);
  logic [SECT_W-1:0] rd_sect;
  logic              unused_mid;

  assign rd_sect    = rd_addr_i[ADDR_W-1 -: SECT_W];
  assign unused_mid = ^rd_addr_i[ADDR_W-SECT_W-1:2];

  always_comb begin
    rd_data_o = array_rdata_i;
    case (state_i)
      ST_AUTO:
        case (rd_addr_i[1:0])
          2'b00:   rd_data_o = ID_MFR;
          2'b01:   rd_data_o = ID_DEV;
          2'b10:   rd_data_o = {7'b0, prot_i[rd_sect]};
          default: rd_data_o = ID_CONT;
        endcase
      ST_BUSY_PGM, ST_BUSY_ERS:
        rd_data_o = {1'b0, tog_i, 6'b0};
      ST_SUSP:
        if (mask_i[rd_sect]) rd_data_o = {1'b1, tog_i, 6'b0};
      default: rd_data_o = array_rdata_i;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECT_W      = 3,
  parameter int BUSY_CYCLES = 24,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_rdata_i,
  output logic [7:0]        rd_data_o,
  input  logic              prot_wr_i,
  input  logic [SECT_W-1:0] prot_sector_i,
  input  logic              prot_val_i,
  output logic              pgm_we_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [7:0]        pgm_data_o,
  output logic              ers_we_o,
  output logic [NSECT-1:0]  ers_mask_o,
  output logic              busy_o
);
  fsm_state_e       state;
  logic             tog;
  logic [NSECT-1:0] prot, mask;

  flash_prot_bank #(.SECT_W(SECT_W)) i_prot (
    .clk_i, .rst_ni, .prot_wr_i, .prot_sector_i, .prot_val_i, .prot_o(prot)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BUSY_CYCLES(BUSY_CYCLES)) i_fsm (
    .clk_i, .rst_ni, .wr_i, .wr_addr_i, .wr_data_i, .rd_i,
    .prot_i(prot), .state_o(state), .tog_o(tog), .mask_o(mask),
    .pgm_we_o, .pgm_addr_o, .pgm_data_o, .ers_we_o, .busy_o
  );

  flash_rd_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_mux (
    .state_i(state), .rd_addr_i, .array_rdata_i, .tog_i(tog),
    .mask_i(mask), .prot_i(prot), .rd_data_o
  );

  assign ers_mask_o = mask;

  AST_PGM_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_we_o |-> busy_o); // R5
  AST_ERS_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_we_o |-> ers_mask_o != '0); // R8
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int BC = 24;
  localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_AUTO = 3, M_ARM = 4,
                 M_E0 = 5, M_E1 = 6, M_E2 = 7, M_BPGM = 8, M_BERS = 9, M_SUSP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, rd = 0, prot_wr = 0, prot_val = 0;
  logic [18:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, arr, rd_data, pgm_data;
  logic [2:0] prot_sect = '0;
  logic [18:0] pgm_addr;
  logic [7:0] ers_mask;
  logic pgm_we, ers_we, busy;

  always #10 clk = ~clk;

  function automatic logic [7:0] arr_of(input logic [18:0] a);
    return a[7:0] ^ {a[18:16], 5'b10101};
  endfunction
  assign arr = arr_of(rd_addr);

  flash_cmd_ctrl #(.ADDR_W(19), .SECT_W(3), .BUSY_CYCLES(BC)) i_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_i(rd), .rd_addr_i(rd_addr), .array_rdata_i(arr), .rd_data_o(rd_data),
    .prot_wr_i(prot_wr), .prot_sector_i(prot_sect), .prot_val_i(prot_val),
    .pgm_we_o(pgm_we), .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data),
    .ers_we_o(ers_we), .ers_mask_o(ers_mask), .busy_o(busy)
  );

  // behavioural reference
  int m_mode, m_rem;
  logic m_tog;
  logic [7:0] m_prot, m_mask, m_pd, m_sel;
  logic [18:0] m_pa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_READ; m_rem = 0; m_tog = 0; m_prot = '0; m_mask = '0; m_pd = '0; m_pa = '0;
    end else begin
      if (rd && (m_mode == M_BPGM || m_mode == M_BERS)) m_tog = ~m_tog;
      if (m_mode == M_BPGM) begin
        if (m_rem == 1) m_mode = M_READ; else m_rem--;
      end else if (m_mode == M_BERS) begin
        if (m_rem == 1) m_mode = M_READ;
        else if (wr && wr_data == 8'hB0) m_mode = M_SUSP;
        else m_rem--;
      end else if (m_mode == M_SUSP) begin
        if (wr && wr_data == 8'h30) m_mode = M_BERS;
      end else if (wr) begin
        case (m_mode)
          M_READ: if (wr_data == 8'hAA && wr_addr[10:0] == 11'h555) m_mode = M_U1;
          M_U1, M_E1: m_mode = (wr_data == 8'h55 && wr_addr[10:0] == 11'h2AA) ? m_mode + 1 : M_READ;
          M_U2: begin
            m_mode = M_READ;
            if (wr_addr[10:0] == 11'h555) begin
              if (wr_data == 8'h90) m_mode = M_AUTO;
              if (wr_data == 8'hA0) m_mode = M_ARM;
              if (wr_data == 8'h80) m_mode = M_E0;
            end
          end
          M_AUTO: m_mode = M_READ;
          M_ARM: begin
            if (m_prot[wr_addr[18:16]]) m_mode = M_READ;
            else begin m_pa = wr_addr; m_pd = wr_data; m_rem = BC; m_mode = M_BPGM; end
          end
          M_E0: m_mode = (wr_data == 8'hAA && wr_addr[10:0] == 11'h555) ? M_E1 : M_READ;
          M_E2: begin
            m_sel = '0;
            if (wr_data == 8'h30) m_sel[wr_addr[18:16]] = ~m_prot[wr_addr[18:16]];
            else if (wr_data == 8'h10 && wr_addr[10:0] == 11'h555) m_sel = ~m_prot;
            if (m_sel != 0) begin m_mask = m_sel; m_rem = BC; m_mode = M_BERS; end
            else m_mode = M_READ;
          end
          default: m_mode = M_READ;
        endcase
      end
      if (prot_wr) m_prot[prot_sect] = prot_val;
    end
  end

  function automatic logic [7:0] m_rd();
    case (m_mode)
      M_AUTO: case (rd_addr[1:0])
        2'd0: return 8'h37;
        2'd1: return 8'h86;
        2'd2: return {7'b0, m_prot[rd_addr[18:16]]};
        default: return 8'h7F;
      endcase
      M_BPGM, M_BERS: return {1'b0, m_tog, 6'b0};
      M_SUSP: return m_mask[rd_addr[18:16]] ? {1'b1, m_tog, 6'b0} : arr;
      default: return arr;
    endcase
  endfunction

  int n_chk = 0, n_fail = 0, busy_seen = 0, pgm_pulses = 0, ers_pulses = 0;
  logic [18:0] got_pa;
  logic [7:0] got_pd, got_mask;
  string cur_req = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic e_busy, e_pw, e_ew;
    e_busy = (m_mode == M_BPGM || m_mode == M_BERS);
    e_pw = (m_mode == M_BPGM && m_rem == 1);
    e_ew = (m_mode == M_BERS && m_rem == 1);
    chk({cur_req, " model rd_data"}, rd_data, m_rd());
    chk({cur_req, " model busy"}, busy, e_busy);
    chk({cur_req, " model pgm_we"}, pgm_we, e_pw);
    chk({cur_req, " model ers_we"}, ers_we, e_ew);
    if (e_pw) begin
      chk({cur_req, " model pgm_addr"}, pgm_addr, m_pa);
      chk({cur_req, " model pgm_data"}, pgm_data, m_pd);
    end
    if (e_ew) chk({cur_req, " model ers_mask"}, ers_mask, m_mask);
    if (busy) busy_seen++;
    if (pgm_we) begin pgm_pulses++; got_pa = pgm_addr; got_pd = pgm_data; end
    if (ers_we) begin ers_pulses++; got_mask = ers_mask; end
  endtask

  task automatic cyc(input logic w, input logic [18:0] wa, input logic [7:0] wd,
                     input logic r, input logic [18:0] ra);
    @(negedge clk);
    wr = w; wr_addr = wa; wr_data = wd; rd = r; rd_addr = ra; prot_wr = 0;
    #5 compare();
  endtask

  task automatic wr1(input logic [18:0] a, input logic [7:0] d); cyc(1, a, d, 0, '0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0); endtask
  task automatic rdc(input logic [18:0] a, input logic [7:0] e, input string tag);
    cyc(0, '0, '0, 1, a); chk(tag, rd_data, e);
  endtask
  task automatic unlock(input logic [7:0] cmd);
    wr1(19'h555, 8'hAA); wr1(19'h2AA, 8'h55); wr1(19'h555, cmd);
  endtask
  task automatic erase(input logic [18:0] a, input logic [7:0] d);
    unlock(8'h80); wr1(19'h555, 8'hAA); wr1(19'h2AA, 8'h55); wr1(a, d);
  endtask
  task automatic set_prot(input logic [2:0] s, input logic v);
    @(negedge clk);
    wr = 0; rd = 0; prot_wr = 1; prot_sect = s; prot_val = v;
    #5 compare();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    rdc(19'h1_2345, arr_of(19'h1_2345), "R1 reset array read");
    chk("R1 reset busy", busy, 0);
    unlock(8'h90);
    rdc(19'h2_0002, 8'h00, "R1 reset prot clear");
    wr1(19'h0, 8'hF0);

    cur_req = "R2";
    unlock(8'h90);
    rdc(19'h0_0000, 8'h37, "R2 mfr code");
    rdc(19'h0_0001, 8'h86, "R2 dev code");
    rdc(19'h3_1003, 8'h7F, "R2 cont code");
    cur_req = "R11";
    wr1(19'h0, 8'hF0);
    rdc(19'h0_0001, arr_of(19'h0_0001), "R11 F0 exits autoselect");
    unlock(8'h90);
    wr1(19'h123, 8'h00);
    rdc(19'h0_0000, arr_of(19'h0_0000), "R11 any write exits");

    cur_req = "R12";
    set_prot(3'd2, 1'b1);
    cur_req = "R3";
    unlock(8'h90);
    rdc(19'h2_0102, 8'h01, "R3 protected sector");
    rdc(19'h5_0002, 8'h00, "R3 unprotected sector");
    wr1(19'h0, 8'hF0);

    cur_req = "R4";
    wr1(19'h555, 8'hAA); wr1(19'h2AB, 8'h55); wr1(19'h555, 8'h90);
    rdc(19'h0_0001, arr_of(19'h0_0001), "R4 bad address step2");
    wr1(19'h555, 8'hAA); wr1(19'h2AA, 8'h54); wr1(19'h555, 8'hA0); wr1(19'h100, 8'h12);
    idle(2);
    chk("R4 bad data no program", busy, 0);
    wr1(19'h555, 8'hAA); wr1(19'h2AA, 8'h55); wr1(19'h555, 8'h77);
    rdc(19'h0_0003, arr_of(19'h0_0003), "R4 bad command");
    wr1(19'h555, 8'hA0); wr1(19'h100, 8'h12);
    idle(2);
    chk("R4 A0 without unlock", busy, 0);
    chk("R4 no strobe", pgm_pulses, 0);

    cur_req = "R5";
    busy_seen = 0;
    unlock(8'hA0);
    wr1(19'h1_0020, 8'h3C);
    chk("R5 not busy while armed", busy, 0);
    cur_req = "R7";
    rdc(19'h4_0000, 8'h00, "R7 status first");
    rdc(19'h0_0010, 8'h40, "R7 status toggled");
    rdc(19'h1_0020, 8'h00, "R7 status toggled back");
    cur_req = "R5";
    idle(BC + 2);
    chk("R5 busy length", busy_seen, BC);
    chk("R5 one strobe", pgm_pulses, 1);
    chk("R5 strobe addr", got_pa, 19'h1_0020);
    chk("R5 strobe data", got_pd, 8'h3C);
    rdc(19'h1_0020, arr_of(19'h1_0020), "R5 back to array read");

    cur_req = "R6";
    unlock(8'hA0);
    wr1(19'h2_0040, 8'h11);
    idle(3);
    chk("R6 protected program busy", busy, 0);
    chk("R6 protected program strobe", pgm_pulses, 1);
    erase(19'h2_0000, 8'h30);
    idle(3);
    chk("R6 protected erase busy", busy, 0);
    rdc(19'h2_0040, arr_of(19'h2_0040), "R6 array read after");

    cur_req = "R8";
    busy_seen = 0;
    erase(19'h5_0000, 8'h30);
    idle(BC + 2);
    chk("R8 sector erase length", busy_seen, BC);
    chk("R8 sector erase strobe", ers_pulses, 1);
    chk("R8 sector mask", got_mask, 8'h20);
    erase(19'h555, 8'h10);
    idle(BC + 2);
    chk("R8 chip erase strobe", ers_pulses, 2);
    chk("R8 chip mask skips protected", got_mask, 8'hFB);

    cur_req = "R9";
    busy_seen = 0;
    erase(19'h6_0000, 8'h30);
    idle(5);
    wr1(19'h0, 8'hB0);
    idle(8);
    chk("R9 suspended not busy", busy, 0);
    chk("R9 no strobe while suspended", ers_pulses, 2);
    rdc(19'h6_0100, 8'hC0, "R9 suspended sector status");
    rdc(19'h6_0101, 8'hC0, "R9 toggle frozen");
    rdc(19'h1_0100, arr_of(19'h1_0100), "R9 other sector array");

    cur_req = "R10";
    wr1(19'h0, 8'h30);
    idle(BC + 2);
    chk("R10 total busy cycles", busy_seen, BC + 1);
    chk("R10 strobe after resume", ers_pulses, 3);
    chk("R10 resumed mask", got_mask, 8'h40);

    cur_req = "R12";
    set_prot(3'd2, 1'b0);
    unlock(8'h90);
    rdc(19'h2_0002, 8'h00, "R12 cleared");
    wr1(19'h0, 8'hF0);
    unlock(8'hA0);
    wr1(19'h2_0040, 8'h11);
    idle(1);
    chk("R12 program allowed after clear", busy, 1);
    idle(BC + 2);

    summary();
    $finish;
  end
endmodule